// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters on an asynchronous serial line. A processor-side write port places one character in a holding buffer. A separate shift register serializes characters from that buffer. Because there are two stages, the processor can supply the next character while the current one is still on the line. The shift register takes the waiting character on a baud tick as soon as it is free. Characters written back to back therefore leave with no idle bit between them.

The bit rate is set outside the block. The block receives `baud_tick`, a single-cycle enable that pulses once per bit time. Two status outputs let software pace itself:

- `hold_empty` says another character may be written.
- `shift_empty` says the whole transmit path has drained, so the line can safely be turned off.

A write made while the buffer is still full replaces the waiting character, and no error is flagged. A transmit-reset input empties the transmit path without a global reset.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: A write (`wr_en` high for one clock) clears both `hold_empty` and `shift_empty` on the following clock. This holds even when a transfer happens on the same clock.
- R3: A frame on `txd` has these bits, and each bit lasts from one baud tick to the next:
  - one start bit of 0;
  - the 8 bits of the character, least significant first;
  - a parity bit, only when `par_en` is 1;
  - one stop bit of 1.
  The parity bit makes the count of ones across data and parity even when `par_odd` is 0, and odd when `par_odd` is 1. `txd` changes only on a clock where `baud_tick` is high, or on a reset. The line rests at 1 between frames.
- R4: The waiting character moves into the shift register, and `hold_empty` sets, on a baud tick where all three hold: `tx_en` is high, a character is waiting, and the shift register is either idle or sending its stop bit. A character that was waiting therefore starts right after the previous stop bit.
- R5: `shift_empty` sets on the baud tick that ends a stop bit when no character is waiting and no write occurs on that clock. `shift_empty` high always implies `hold_empty` high.
- R6: A write while `hold_empty` is 0 replaces the waiting character. Only the last character written is sent, and no error is indicated.
- R7: `tx_rst` high for a clock discards the waiting character and any frame in progress. On the next clock, `txd`, `hold_empty` and `shift_empty` are all 1.
- R8: While `tx_en` is low, no new frame starts. A waiting character stays waiting with `hold_empty` at 0, and writes are still accepted.
- R9: When a write coincides with a transfer, the shift register sends the older character and the buffer keeps the newly written one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, asynchronous, active low |
| tx_en | input | 1 | Permits new frames to start |
| tx_rst | input | 1 | Synchronous transmit reset, active high |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to write |
| par_en | input | 1 | Adds a parity bit to frames loaded while high |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding buffer can take a character |
| shift_empty | output | 1 | Buffer and shift register both drained |

## Verification
The assertions assume these input conditions:

- `baud_tick` is a single-cycle pulse with at least one clock between pulses.
- `tx_rst` and writes are synchronous to `clk`.
- `rst_n` is asserted only from time zero.

The stimulus drives every input on the falling clock edge. It produces ticks from a free-running divide-by-four counter and asserts reset only at the start. Writes, parity settings and enable changes are random, and some writes are timed to land on the stop-bit tick so that R9 and the overwrite case of R6 both occur.

// File: rtl/uart_tx_dbuf.sv
`timescale 1ns/1ps
module uart_tx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tx_rst,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          txd,
  output logic          hold_empty,
  output logic          shift_empty
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);

  logic [DW-1:0] hold_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          he_q, se_q;

  wire busy = cnt_q != '0;
  wire last = cnt_q == CW'(1);
  wire free = baud_tick && (!busy || last);
  wire load = free && !he_q && tx_en;
  wire par  = (^hold_q) ^ par_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '1;
      cnt_q  <= '0;
      he_q   <= 1'b1;
      se_q   <= 1'b1;
    end else if (tx_rst) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      he_q   <= 1'b1;
      se_q   <= 1'b1;
    end else begin
      if (load) begin
        sh_q  <= par_en ? {1'b1, par, hold_q, 1'b0} : {2'b11, hold_q, 1'b0};
        cnt_q <= par_en ? CW'(FW) : CW'(FW - 1);
        he_q  <= 1'b1;
      end else if (baud_tick && busy) begin
        sh_q  <= {1'b1, sh_q[FW-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end
      if (free && he_q && !wr_en)
        se_q <= 1'b1;
      if (wr_en) begin
        hold_q <= wr_data;
        he_q   <= 1'b0;
        se_q   <= 1'b0;
      end
    end
  end

  assign txd         = busy ? sh_q[0] : 1'b1;
  assign hold_empty  = he_q;
  assign shift_empty = se_q;
endmodule

module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_rst,
  input logic baud_tick,
  input logic wr_en,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty
);
  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |=> (txd && hold_empty && shift_empty)); // R1
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !tx_rst) |=> (!hold_empty && !shift_empty)); // R2
  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!baud_tick && !tx_rst) |=> $stable(txd)); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> txd); // R3
  AST_SE_NEEDS_HE: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> hold_empty); // R5
  AST_TXRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) tx_rst |=> (txd && hold_empty && shift_empty)); // R7
  AST_DIS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && !hold_empty && !tx_rst) |=> !hold_empty); // R8
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk i_chk (.*);

// File: tb/test_uart_tx_dbuf.sv
`timescale 1ns/1ps
module test_uart_tx_dbuf;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b1, tx_rst = 1'b0, baud_tick = 1'b0;
  logic wr_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, hold_empty, shift_empty;
  int total = 0, bad = 0, tdiv = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_tx_dbuf i_uart_tx_dbuf (.*);

  // behavioural reference
  bit q[$];
  bit m_he = 1, m_se = 1;
  logic [7:0] m_hold = '0;

  always @(posedge clk) begin
    if (!rst_n || tx_rst) begin
      q.delete(); m_he = 1; m_se = 1;
    end else begin
      if (baud_tick) begin
        if (q.size() <= 1 && !m_he && tx_en) begin
          q.delete();
          q.push_back(1'b0);
          for (int i = 0; i < 8; i++) q.push_back(m_hold[i]);
          if (par_en) q.push_back((^m_hold) ^ par_odd);
          q.push_back(1'b1);
          m_he = 1;
        end else begin
          if (q.size() > 0) void'(q.pop_front());
          if (q.size() == 0 && m_he && !wr_en) m_se = 1;
        end
      end
      if (wr_en) begin m_hold = wr_data; m_he = 0; m_se = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  always @(negedge clk) if (!done) begin
    bit m_txd;
    m_txd = (q.size() > 0) ? q[0] : 1'b1;
    check(txd == m_txd, "R3/R4/R6/R9 txd", txd, m_txd);
    check(hold_empty == m_he, "R4 hold_empty", hold_empty, m_he);
    check(shift_empty == m_se, "R5 shift_empty", shift_empty, m_se);
  end

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baud_tick = (tdiv == 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    idle(3);
    check(txd && hold_empty && shift_empty, "R1 reset state", {txd, hold_empty, shift_empty}, 7);
    rst_n = 1;
    idle(1);
    check(txd && hold_empty && shift_empty, "R1 after release", {txd, hold_empty, shift_empty}, 7);

    write(8'hA5);
    check(!hold_empty || !shift_empty, "R2 flags after write", {hold_empty, shift_empty}, 0);
    check(!shift_empty, "R2 shift_empty cleared", shift_empty, 0);
    idle(80);
    check(shift_empty, "R5 drained", shift_empty, 1);

    // back to back with overwrite
    write(8'h3C); write(8'hC3); write(8'h0F);
    idle(120);
    par_en = 1; par_odd = 0; write(8'h81); write(8'h7E); idle(120);
    par_odd = 1; write(8'h01); idle(70);

    // disabled transmitter
    tx_en = 0; write(8'h55); idle(40);
    check(!hold_empty, "R8 char still waiting", hold_empty, 0);
    check(txd, "R8 line idle", txd, 1);
    write(8'hAA); idle(10);
    check(!hold_empty && !shift_empty, "R8 write accepted", {hold_empty, shift_empty}, 0);
    tx_en = 1; idle(80);
    check(shift_empty, "R8 sent after enable", shift_empty, 1);

    // transmit reset mid-frame
    write(8'h12); idle(14); write(8'h34);
    @(negedge clk); tx_rst = 1; @(negedge clk); tx_rst = 0;
    check(txd && hold_empty && shift_empty, "R7 after tx_rst", {txd, hold_empty, shift_empty}, 7);
    idle(60);
    check(txd, "R7 discarded stays idle", txd, 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 19) == 0);
      wr_data = 8'($urandom);
      par_en = 1'($urandom); par_odd = 1'($urandom);
      tx_en = ($urandom_range(0, 9) != 0);
      tx_rst = ($urandom_range(0, 299) == 0);
    end
    @(negedge clk); wr_en = 0; tx_rst = 0; tx_en = 1;
    idle(100);
    check(shift_empty && hold_empty, "R5 drained at end", {hold_empty, shift_empty}, 3);
    finish_run();
  end
endmodule